// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside the register file of a 16550-style serial port. It gathers the interrupt sources the rest of the port reports (line status error bits, received-data readiness, the receive FIFO fill level against its trigger level, a character-timeout flag, modem-status delta bits and the transmit-holding-empty condition), filters each through a four-bit enable register, and reduces them to one identification byte and one level-sensitive interrupt request.

The transmit-holding-empty source is the only one held as state inside the block. It is armed by a transmit FIFO flush and by turning its enable bit on while the holding register is empty. It is disarmed by a holding register write, by turning the enable bit off, and by software reading the identification byte while that byte shows the holding-empty code. All other sources are level inputs whose owners clear them. The identification byte and the request line are registered. Both reflect the sources and enable register as they stand after the current clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01, the request line is low and the enable register reads 0x00.
- R2: The low nibble of the identification byte shows the highest-priority active source, in this order: line error 0x6, character timeout 0xC, received data 0x4, holding empty 0x2, modem change 0x0. With no active source it shows 0x1.
- R3: The line error source is active when enable bit 2 is set and any of line_stat bits 1 to 4 (overrun, parity, framing, break) is set. Line_stat bit 0 (data ready) alone never raises it.
- R4: The character timeout source is active only when char_tmo is high and enable bit 0 is set.
- R5: The received data source needs enable bit 0 and line_stat bit 0. With fifo_on high it also needs rx_level >= rx_trigger. With fifo_on low, data ready alone is enough.
- R6: Reading the identification byte (iid_rd) while it shows 0x2 clears the holding-empty pending flag.
- R7: A write to the enable register that changes bit 1 sets the pending flag if the new bit 1 is 1 and thr_empty is high, and clears it otherwise. A write that leaves bit 1 unchanged keeps the flag.
- R8: A holding register write (thr_wr) clears the pending flag. A transmit FIFO flush (txf_flush) sets it.
- R9: Bits 7:6 of the identification byte read 11 when fifo_on is high and 00 otherwise. Bits 5:4 always read 0.
- R10: An enable register write stores only bits 3:0 of ien_wdata. Bits 7:4 of ien_q always read 0.
- R11: irq is high exactly when the low nibble of iid_q differs from 0x1. Both outputs change at the first clock edge after the causing input or strobe.
- R12: The modem change source is active when enable bit 3 is set and any mdm_delta bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| iid_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| txf_flush | input | 1 | Transmit FIFO flush strobe |
| thr_empty | input | 1 | Holding register empty status |
| line_stat | input | 5 | Line status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break |
| mdm_delta | input | 4 | Modem status change bits |
| fifo_on | input | 1 | FIFO mode enabled |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive trigger level |
| char_tmo | input | 1 | Character timeout pending |
| ien_q | output | 8 | Enable register read value |
| iid_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest state to reach is a holding-empty pending flag that disagrees with thr_empty. This happens after a read clears the flag while the holding register is still empty, or after a flush sets it while the register is full. Random strobes only reach it by chance. Directed sequences therefore toggle enable bit 1 and read the identification byte while higher sources are held off, so that code 0x2 is actually visible when the read happens. Random cycles then mix the strobes one at a time with random source levels against a bench model of the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      SRC_MDM  = 4'h0,
      SRC_NONE = 4'h1,
      SRC_THRE = 4'h2,
      SRC_RXD  = 4'h4,
      SRC_LINE = 4'h6,
      SRC_TMO  = 4'hC
   } irq_src_e;

   localparam int IEN_BITS = 4;
   localparam int IEN_RXD  = 0;
   localparam int IEN_THRE = 1;
   localparam int IEN_LINE = 2;
   localparam int IEN_MDM  = 3;
endpackage

// File: rtl/uart_irq_ien_reg.sv
module uart_irq_ien_reg
   import uart_irq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [7:0]          wdata,
   output logic [IEN_BITS-1:0] ien_d,
   output logic [IEN_BITS-1:0] ien_r
);
   always_comb begin
      ien_d = ien_r;
      if (wr) ien_d = wdata[IEN_BITS-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ien_r <= '0;
      else        ien_r <= ien_d;
   end
endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ien_wr,
   input  logic en_old,
   input  logic en_new,
   input  logic thr_empty,
   input  logic thr_wr,
   input  logic txf_flush,
   input  logic iid_rd,
   input  logic shown_thre,
   output logic pend_d,
   output logic pend_r
);
   logic en_flip;
   assign en_flip = ien_wr && (en_old != en_new);

   always_comb begin
      pend_d = pend_r;
      if (txf_flush)                 pend_d = 1'b1;
      else if (thr_wr)               pend_d = 1'b0;
      else if (en_flip)              pend_d = en_new && thr_empty;
      else if (iid_rd && shown_thre) pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_r <= 1'b0;
      else        pend_r <= pend_d;
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int CNT_W         = 5,
   parameter bit TMO_NEEDS_RXD = 1'b1
) (
   input  logic [IEN_BITS-1:0] ien,
   input  logic                thre_pend,
   input  logic [4:0]          line_stat,
   input  logic [3:0]          mdm_delta,
   input  logic                fifo_on,
   input  logic [CNT_W-1:0]    rx_level,
   input  logic [CNT_W-1:0]    rx_trigger,
   input  logic                char_tmo,
   output irq_src_e            src
);
   logic act_line, act_tmo, act_rxd, act_thre, act_mdm, level_ok;

   assign act_line = ien[IEN_LINE] && (|line_stat[4:1]);
   assign level_ok = !fifo_on || (rx_level >= rx_trigger);
   assign act_rxd  = ien[IEN_RXD] && line_stat[0] && level_ok;
   assign act_thre = ien[IEN_THRE] && thre_pend;
   assign act_mdm  = ien[IEN_MDM] && (|mdm_delta);

   generate
      if (TMO_NEEDS_RXD) begin : g_tmo_gated
         assign act_tmo = char_tmo && ien[IEN_RXD];
      end else begin : g_tmo_free
         assign act_tmo = char_tmo;
      end
   endgenerate

   always_comb begin
      if (act_line)      src = SRC_LINE;
      else if (act_tmo)  src = SRC_TMO;
      else if (act_rxd)  src = SRC_RXD;
      else if (act_thre) src = SRC_THRE;
      else if (act_mdm)  src = SRC_MDM;
      else               src = SRC_NONE;
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int CNT_W         = 5,
   parameter bit TMO_NEEDS_RXD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ien_wr,
   input  logic [7:0]       ien_wdata,
   input  logic             iid_rd,
   input  logic             thr_wr,
   input  logic             txf_flush,
   input  logic             thr_empty,
   input  logic [4:0]       line_stat,
   input  logic [3:0]       mdm_delta,
   input  logic             fifo_on,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] rx_trigger,
   input  logic             char_tmo,
   output logic [7:0]       ien_q,
   output logic [7:0]       iid_q,
   output logic             irq
);
   localparam int PAD_W = 8 - IEN_BITS;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("uart_irq_ident: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [IEN_BITS-1:0] ien_d, ien_r;
   logic                pend_d, pend_r;
   logic                shown_thre;
   irq_src_e            src_d;

   uart_irq_ien_reg u_ien (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ien_wr),
      .wdata (ien_wdata),
      .ien_d (ien_d),
      .ien_r (ien_r)
   );

   assign shown_thre = (iid_q[3:0] == SRC_THRE);

   uart_irq_thre_track u_thre (
      .clk        (clk),
      .rst_n      (rst_n),
      .ien_wr     (ien_wr),
      .en_old     (ien_r[IEN_THRE]),
      .en_new     (ien_d[IEN_THRE]),
      .thr_empty  (thr_empty),
      .thr_wr     (thr_wr),
      .txf_flush  (txf_flush),
      .iid_rd     (iid_rd),
      .shown_thre (shown_thre),
      .pend_d     (pend_d),
      .pend_r     (pend_r)
   );

   uart_irq_prio #(.CNT_W(CNT_W), .TMO_NEEDS_RXD(TMO_NEEDS_RXD)) u_prio (
      .ien        (ien_d),
      .thre_pend  (pend_d),
      .line_stat  (line_stat),
      .mdm_delta  (mdm_delta),
      .fifo_on    (fifo_on),
      .rx_level   (rx_level),
      .rx_trigger (rx_trigger),
      .char_tmo   (char_tmo),
      .src        (src_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iid_q <= {4'h0, SRC_NONE};
         irq   <= 1'b0;
      end else begin
         iid_q <= {{2{fifo_on}}, 2'b00, src_d};
         irq   <= (src_d != SRC_NONE);
      end
   end

   assign ien_q = {{PAD_W{1'b0}}, ien_r};
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int CNT_W = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ien_wr,
   input logic [7:0] ien_wdata,
   input logic       iid_rd,
   input logic       txf_flush,
   input logic [4:0] line_stat,
   input logic       fifo_on,
   input logic [7:0] ien_q,
   input logic [7:0] iid_q,
   input logic       irq
);
   p_line_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q[2] && !ien_wr && (|line_stat[4:1])) |=> (iid_q[3:0] == 4'h6 && irq));

   p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_q[0] && !ien_wr) |=> (iid_q[3:0] != 4'hC && iid_q[3:0] != 4'h4));

   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && iid_q[3:0] == 4'h2 && !ien_wr && !txf_flush) |=> (iid_q[3:0] != 4'h2));

   p_fifo_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (iid_q[7:6] == {2{$past(fifo_on)}} && iid_q[5:4] == 2'b00));

   p_ien_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ien_wr |=> (ien_q == {4'h0, $past(ien_wdata[3:0])}));

   p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_q[3:0] == 4'h0 || iid_q[3:0] == 4'h1 || iid_q[3:0] == 4'h2 ||
       iid_q[3:0] == 4'h4 || iid_q[3:0] == 4'h6 || iid_q[3:0] == 4'hC));

   p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (iid_q[3:0] != 4'h1));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ien_wr    (ien_wr),
   .ien_wdata (ien_wdata),
   .iid_rd    (iid_rd),
   .txf_flush (txf_flush),
   .line_stat (line_stat),
   .fifo_on   (fifo_on),
   .ien_q     (ien_q),
   .iid_q     (iid_q),
   .irq       (irq)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ien_wr = 0, iid_rd = 0, thr_wr = 0, txf_flush = 0, thr_empty = 0;
   logic [7:0]    ien_wdata = 0;
   logic [4:0]    line_stat = 0;
   logic [3:0]    mdm_delta = 0;
   logic          fifo_on = 0, char_tmo = 0;
   logic [CW-1:0] rx_level = 0, rx_trigger = 1;
   logic [7:0]    ien_q, iid_q;
   logic          irq;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   logic [3:0] m_ien = 0;
   logic       m_pend = 0;
   logic [7:0] m_iid = 8'h01;

   always #4 clk = ~clk;

   uart_irq_ident #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
      .iid_rd(iid_rd), .thr_wr(thr_wr), .txf_flush(txf_flush),
      .thr_empty(thr_empty), .line_stat(line_stat), .mdm_delta(mdm_delta),
      .fifo_on(fifo_on), .rx_level(rx_level), .rx_trigger(rx_trigger),
      .char_tmo(char_tmo), .ien_q(ien_q), .iid_q(iid_q), .irq(irq));

   function automatic logic [3:0] want_code(input logic [3:0] en, input logic pend);
      if (en[2] && line_stat[4:1] != 0)                    return 4'h6;
      if (en[0] && char_tmo)                               return 4'hC;
      if (en[0] && line_stat[0] && (!fifo_on || rx_level >= rx_trigger)) return 4'h4;
      if (en[1] && pend)                                   return 4'h2;
      if (en[3] && mdm_delta != 0)                         return 4'h0;
      return 4'h1;
   endfunction

   task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // advance one clock with the currently driven inputs and compare against the model
   task automatic step(input string req);
      logic [3:0] nx_ien;
      logic       nx_pend;
      logic [3:0] code;
      nx_ien  = ien_wr ? ien_wdata[3:0] : m_ien;
      nx_pend = m_pend;
      if (txf_flush)                                  nx_pend = 1'b1;
      else if (thr_wr)                                nx_pend = 1'b0;
      else if (ien_wr && (nx_ien[1] != m_ien[1]))     nx_pend = nx_ien[1] && thr_empty;
      else if (iid_rd && m_iid[3:0] == 4'h2)          nx_pend = 1'b0;
      code   = want_code(nx_ien, nx_pend);
      m_ien  = nx_ien;
      m_pend = nx_pend;
      m_iid  = {{2{fifo_on}}, 2'b00, code};
      @(posedge clk);
      #2;
      check8(req, "iid", iid_q, m_iid);
      check8(req, "irq", {7'd0, irq}, {7'd0, code != 4'h1});
      check8(req, "ien", ien_q, {4'h0, m_ien});
      ien_wr = 0; iid_rd = 0; thr_wr = 0; txf_flush = 0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      #2;
      // R1 reset values
      check8("R1", "iid", iid_q, 8'h01);
      check8("R1", "irq", {7'd0, irq}, 8'h00);
      check8("R1", "ien", ien_q, 8'h00);
      rst_n = 1;
      step("R1");

      // R10 only low bits kept
      ien_wr = 1; ien_wdata = 8'hF0; step("R10");
      ien_wr = 1; ien_wdata = 8'h00; step("R10");

      // R7 arm on enable rising with empty holding register
      thr_empty = 1;
      ien_wr = 1; ien_wdata = 8'h02; step("R7");
      check8("R7", "code", iid_q, 8'h02);
      // R7 rewrite with same bit keeps flag
      ien_wr = 1; ien_wdata = 8'h02; step("R7");
      // R6 read while code 2 clears
      iid_rd = 1; step("R6");
      check8("R6", "code", iid_q, 8'h01);
      // R8 flush sets, holding write clears
      txf_flush = 1; step("R8");
      check8("R8", "code", iid_q, 8'h02);
      thr_wr = 1; thr_empty = 0; step("R8");
      check8("R8", "code", iid_q, 8'h01);
      // R7 enable rising with full holding register does not arm
      ien_wr = 1; ien_wdata = 8'h00; step("R7");
      ien_wr = 1; ien_wdata = 8'h02; step("R7");
      check8("R7", "code", iid_q, 8'h01);

      // R3 data ready alone is not a line error
      ien_wr = 1; ien_wdata = 8'h0F; line_stat = 5'b00001; step("R3");
      check8("R5", "code", iid_q, 8'h04);
      line_stat = 5'b00011; step("R3");
      check8("R3", "code", iid_q, 8'h06);

      // R11 irq follows one cycle later
      line_stat = 5'b00000;
      #1;
      check8("R11", "irq before edge", {7'd0, irq}, 8'h01);
      step("R11");
      check8("R11", "irq after edge", {7'd0, irq}, 8'h00);

      // R4 timeout gated by bit 0
      char_tmo = 1; ien_wr = 1; ien_wdata = 8'h0E; step("R4");
      ien_wr = 1; ien_wdata = 8'h0F; step("R4");
      check8("R4", "code", iid_q, 8'h0C);
      char_tmo = 0;

      // R5 and R9 FIFO trigger
      fifo_on = 1; line_stat = 5'b00001; rx_trigger = 4; rx_level = 3; step("R5");
      check8("R9", "fifo bits", iid_q & 8'hF0, 8'hC0);
      rx_level = 4; step("R5");
      check8("R5", "code", iid_q, 8'hC4);
      fifo_on = 0; line_stat = 0; rx_level = 0; step("R9");

      // R12 modem change
      ien_wr = 1; ien_wdata = 8'h08; mdm_delta = 4'b0100; step("R12");
      check8("R12", "code", iid_q, 8'h00);
      mdm_delta = 0; step("R12");

      // R2 random mixture
      for (int i = 0; i < 600; i++) begin
         int s;
         s = $urandom_range(0, 9);
         ien_wr    = (s == 0);
         iid_rd    = (s == 1 || s == 2);
         thr_wr    = (s == 3);
         txf_flush = (s == 4);
         ien_wdata = 8'($urandom);
         thr_empty = 1'($urandom);
         line_stat = ($urandom_range(0, 3) == 0) ? 5'($urandom) : {4'b0, 1'($urandom)};
         mdm_delta = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0;
         fifo_on   = 1'($urandom);
         char_tmo  = ($urandom_range(0, 4) == 0);
         rx_level  = CW'($urandom_range(0, 16));
         case ($urandom_range(0, 3))
            0: rx_trigger = 1;
            1: rx_trigger = 4;
            2: rx_trigger = 8;
            default: rx_trigger = 14;
         endcase
         step("R2");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule